// File: doc/BRIEF.md
# Packed Coefficient Staging Buffer

This block sits behind a byte-level serial slave front end. It receives write transfers that load filter coefficients straight into the coefficient memory of an audio processor. The first byte of a transfer gives the memory start address. The bytes that follow carry 12-bit coefficients packed end to end, most significant bit first, so two coefficients fill exactly three bytes. The block reassembles the coefficients into a small shadow buffer and decides, byte by byte, whether to acknowledge.

Nothing reaches coefficient memory while bytes are still arriving. When the transfer closes, either with STOP or with a repeated START, the block replays every complete coefficient it staged into consecutive memory locations, one write per clock. The set therefore changes in one short burst rather than across many audio samples. While that burst runs, the block reports itself busy and refuses new bytes.

Top module: `coef_stager`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ack`, `busy` and `ram_we` are 0.
- R2: In a transfer, the first byte accepted after START is the start address, and it is acknowledged. The data bytes are split into 12-bit words MSB first: word 0 is {byte1, byte2[7:4]} and word 1 is {byte2[3:0], byte3}. This pattern repeats every three bytes.
- R3: The buffer holds DEPTH words (8 by default). A data byte whose first bit falls in word index DEPTH or higher is NACKed. From then on, every byte of that transfer is NACKed and discarded, and the words already staged are still committed unchanged.
- R4: An end event with N > 0 complete words raises `busy` in the next cycle. Writes then follow in N consecutive cycles, starting one cycle after `busy` rises. Word k goes to address start+k. `busy` is low in the cycle that shows the last write.
- R5: A word whose 12 bits are not all received is never written. When an odd number of words is sent, the low nibble of the final byte is ignored.
- R6: Write addresses are not range-checked and wrap modulo 2^AW (start 0xFD with 6 words writes 0xFD, 0xFE, 0xFF, 0x00, 0x01, 0x02).
- R7: A byte presented while `busy` is high is NACKed. Every later byte of that transfer is also NACKed, and none of them is staged.
- R8: `ack` is updated in the cycle after `byte_vld` and holds its value until the next byte.
- R9: A byte outside a transfer (before any START or after STOP) is NACKed and staged nowhere. So is a byte that arrives in the same cycle as START or STOP.
- R10: A transfer that ends with no complete word produces no write and does not raise `busy`.
- R11: A repeated START ends the current transfer and opens a new one. The word count is reset, and the next accepted byte is taken as the new start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| start_evt | input | 1 | One-cycle strobe: START or repeated START detected |
| stop_evt | input | 1 | One-cycle strobe: STOP detected |
| ack | output | 1 | 1 = acknowledge the most recent byte, 0 = NACK |
| busy | output | 1 | Commit burst in progress |
| ram_we | output | 1 | Coefficient memory write enable |
| ram_addr | output | AW | Coefficient memory write address |
| ram_wdata | output | 12 | Coefficient memory write data |

## Verification
The final write of a commit burst and the acceptance of the first byte of the next transfer share one clock cycle. `busy` has already dropped while `ram_we` still shows the last word. The bench provokes this by ending a transfer with a repeated START and then presenting the new address byte exactly in the cycle where it sees `ram_we` high and `busy` low. It expects an acknowledge for that byte, the correct final address and data in that same cycle, and a correct later commit of the new transfer. A second collision places a byte in the same cycle as STOP; that byte must be NACKed and left out of the committed set.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int COEF_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  // Position inside a three-byte group carrying two coefficients
  typedef enum logic [1:0] {
    PH_HEAD  = 2'd0,  // upper 8 bits of the even word
    PH_SPLIT = 2'd1,  // low nibble of even word, high nibble of odd word
    PH_TAIL  = 2'd2   // lower 8 bits of the odd word
  } phase_t;

  function automatic logic [COEF_W-1:0] join_even(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] mid);
    return {hi, mid[BYTE_W-1:NIB_W]};
  endfunction

  function automatic logic [COEF_W-1:0] join_odd(input logic [NIB_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/cs_buf.sv
// Shadow store for staged coefficients: one write port, one registered
// read port, no reset on the array so it maps onto block or distributed RAM.
module cs_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 12,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[ridx];
  end

endmodule

// File: rtl/cs_unpack.sv
// Byte parser: tracks the transfer, unpacks 12-bit words, decides ACK/NACK
// and signals the commit engine when a transfer ends.
module cs_unpack
  import cs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              busy,
  output logic              ack,
  output logic              bw_en,
  output logic [IW-1:0]     bw_idx,
  output logic [COEF_W-1:0] bw_data,
  output logic              go,
  output logic [AW-1:0]     go_addr,
  output logic [CNTW-1:0]   go_cnt
);

  logic              active;     // between START and STOP
  logic              have_addr;  // start address byte already taken
  logic              halted;     // a byte of this transfer was refused
  phase_t            ph;
  logic [CNTW-1:0]   cnt;        // complete words staged in this transfer
  logic [BYTE_W-1:0] hold;
  logic [AW-1:0]     saddr;

  logic take, fits, good, end_evt;

  always_comb begin
    end_evt = stop_evt | (start_evt & active);
    take    = byte_vld & ~start_evt & ~stop_evt;
    // the first bit of every data byte lands in word index cnt
    fits    = cnt < CNTW'(DEPTH);
    good    = take & active & ~busy & ~halted & (~have_addr | fits);
  end

  assign go      = end_evt & (cnt != '0);
  assign go_addr = saddr;
  assign go_cnt  = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      have_addr <= 1'b0;
      halted    <= 1'b0;
      ph        <= PH_HEAD;
      cnt       <= '0;
      hold      <= '0;
      saddr     <= '0;
      ack       <= 1'b0;
      bw_en     <= 1'b0;
      bw_idx    <= '0;
      bw_data   <= '0;
    end else begin
      bw_en <= 1'b0;
      if (byte_vld) ack <= good;
      if (take & active & ~good) halted <= 1'b1;

      if (good) begin
        if (!have_addr) begin
          saddr     <= AW'(byte_data);
          have_addr <= 1'b1;
        end else begin
          case (ph)
            PH_HEAD: begin
              hold <= byte_data;
              ph   <= PH_SPLIT;
            end
            PH_SPLIT: begin
              bw_en   <= 1'b1;
              bw_idx  <= IW'(cnt);
              bw_data <= join_even(hold, byte_data);
              hold    <= {{(BYTE_W-NIB_W){1'b0}}, byte_data[NIB_W-1:0]};
              cnt     <= cnt + CNTW'(1);
              ph      <= PH_TAIL;
            end
            PH_TAIL: begin
              bw_en   <= 1'b1;
              bw_idx  <= IW'(cnt);
              bw_data <= join_odd(hold[NIB_W-1:0], byte_data);
              cnt     <= cnt + CNTW'(1);
              ph      <= PH_HEAD;
            end
            default: ph <= PH_HEAD;
          endcase
        end
      end

      if (start_evt) begin
        active    <= 1'b1;
        have_addr <= 1'b0;
        halted    <= 1'b0;
        ph        <= PH_HEAD;
        cnt       <= '0;
      end else if (stop_evt) begin
        active    <= 1'b0;
        have_addr <= 1'b0;
        halted    <= 1'b0;
        ph        <= PH_HEAD;
        cnt       <= '0;
      end
    end
  end

  // R3: the staged count never exceeds the buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH))
    else $error("staged count beyond buffer depth");

  // R3: once refused, later bytes of the same transfer stay refused
  a_r3_sticky_nack: assert property (@(posedge clk) disable iff (rst)
    (halted && active && byte_vld && !start_evt && !stop_evt) |=> !ack)
    else $error("byte accepted after a refusal");

  // R7: bytes offered during a commit are refused
  a_r7_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && busy) |=> !ack)
    else $error("byte accepted while busy");

  // R9: bytes outside a transfer are refused
  a_r9_idle_nack: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !active) |=> !ack)
    else $error("byte accepted outside a transfer");

endmodule

// File: rtl/cs_commit.sv
// Commit engine: replays staged words into coefficient memory, one per clock.
module cs_commit #(
  parameter int DEPTH  = 8,
  parameter int AW     = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [AW-1:0]   go_addr,
  input  logic [CNTW-1:0] go_cnt,
  output logic            busy,
  output logic            rd_en,
  output logic [IW-1:0]   rd_idx,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr
);

  logic [IW-1:0] cidx;
  logic [IW-1:0] last_idx;
  logic [AW-1:0] caddr;

  assign rd_en  = busy;
  assign rd_idx = cidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      cidx     <= '0;
      last_idx <= '0;
      caddr    <= '0;
    end else begin
      ram_we <= busy;
      if (busy) begin
        ram_addr <= caddr;
        caddr    <= caddr + AW'(1);   // wraps at the address width
        cidx     <= cidx + IW'(1);
        if (cidx == last_idx) busy <= 1'b0;
      end
      if (go) begin
        busy     <= 1'b1;
        caddr    <= go_addr;
        cidx     <= '0;
        last_idx <= IW'(go_cnt) - IW'(1);
      end
    end
  end

  // R4: back-to-back writes step the address by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + AW'(1)))
    else $error("write address did not advance by one");

  // R4: busy falls exactly when the last write is presented
  a_r4_tail_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ram_we)
    else $error("busy fell without a final write");

  // R7: a new commit is only launched from idle
  a_r7_go_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy)
    else $error("commit launched while busy");

endmodule

// File: rtl/coef_stager.sv
module coef_stager #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int CW   = cs_pkg::COEF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          start_evt,
  input  logic          stop_evt,
  output logic          ack,
  output logic          busy,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [CW-1:0] ram_wdata
);

  logic            bw_en;
  logic [IW-1:0]   bw_idx;
  logic [CW-1:0]   bw_data;
  logic            go;
  logic [AW-1:0]   go_addr;
  logic [CNTW-1:0] go_cnt;
  logic            rd_en;
  logic [IW-1:0]   rd_idx;

  cs_unpack #(.DEPTH(DEPTH), .AW(AW)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .ack       (ack),
    .bw_en     (bw_en),
    .bw_idx    (bw_idx),
    .bw_data   (bw_data),
    .go        (go),
    .go_addr   (go_addr),
    .go_cnt    (go_cnt)
  );

  cs_buf #(.DEPTH(DEPTH), .W(CW)) u_buf (
    .clk   (clk),
    .we    (bw_en),
    .widx  (bw_idx),
    .wdata (bw_data),
    .re    (rd_en),
    .ridx  (rd_idx),
    .rdata (ram_wdata)
  );

  cs_commit #(.DEPTH(DEPTH), .AW(AW)) u_commit (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_addr  (go_addr),
    .go_cnt   (go_cnt),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
  );

endmodule

// File: tb/sim_coef_stager.sv
`timescale 1ns/1ps
module sim_coef_stager;
  localparam int DEPTH = 8;
  localparam int AW    = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic byte_vld = 1'b0, start_evt = 1'b0, stop_evt = 1'b0;
  logic [7:0] byte_data = 8'h00;
  wire ack, busy, ram_we;
  wire [AW-1:0] ram_addr;
  wire [11:0] ram_wdata;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coef_stager #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .ack(ack), .busy(busy),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  function automatic int cval(input int s, input int k);
    return (s * 1103 + k * 2731 + 5) & 'hFFF;
  endfunction

  // byte j of the MSB-first packed stream of words cval(s,0), cval(s,1), ...
  function automatic logic [7:0] pk(input int s, input int j);
    logic [7:0] r;
    logic [11:0] c;
    for (int b = 0; b < 8; b++) begin
      int i = 8 * j + b;
      c = 12'(cval(s, i / 12));
      r[7 - b] = c[11 - (i % 12)];
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input int exp, input string req);
    byte_vld = 1'b1; byte_data = b;
    @(negedge clk);
    byte_vld = 1'b0;
    chk(req, ack, exp);
  endtask

  task automatic pulse_evt(input bit rep);
    if (rep) start_evt = 1'b1; else stop_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0;
  endtask

  // called one negedge after the end event
  task automatic collect(input int n, input int a, input int s, input string req);
    chk({req, " busy after end"}, busy, (n > 0) ? 1 : 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({req, " we"}, ram_we, 1);
      chk({req, " addr"}, ram_addr, (a + k) & 255);
      chk({req, " data"}, ram_wdata, cval(s, k));
      chk({req, " busy during burst"}, busy, (k < n - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({req, " we idle"}, ram_we, 0);
    chk({req, " busy idle"}, busy, 0);
  endtask

  task automatic xfer(input int a, input int nb, input int s, input bit rep, input string req);
    int acc = 0;
    int n;
    pulse_evt(1'b1);
    send(8'(a), 1, {req, " R2 address ack"});
    for (int j = 0; j < nb; j++) begin
      int g = j / 3;
      int p = j % 3;
      int idx = (p == 2) ? 2 * g + 1 : 2 * g;
      int e = (idx < DEPTH) ? 1 : 0;
      send(pk(s, j), e, {req, " data ack"});
      if (e == 1) acc++;
    end
    n = (acc * 8) / 12;
    if (n > DEPTH) n = DEPTH;
    pulse_evt(rep);
    collect(n, a, s, req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 ack in reset", ack, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 we in reset", ram_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack after reset", ack, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 we after reset", ram_we, 0);

    send(8'h55, 0, "R9 byte before any start");
    chk("R9 no write before start", ram_we, 0);

    // sweep over word counts 0..10, alternating STOP and repeated START
    for (int n = 0; n <= 10; n++) begin
      string t;
      t = $sformatf("R4 n=%0d%s%s%s", n, (n > DEPTH) ? " R3" : "",
                    (n % 2 == 1) ? " R5" : "", (n == 0) ? " R10" : "");
      xfer((n * 37 + 3) & 255, (12 * n + 7) / 8, n + 1, n[0], t);
    end

    xfer(8'hFD, 9, 77, 1'b0, "R6 wrap");
    xfer(16, 4, 5, 1'b0, "R5 partial word");
    xfer(60, 1, 6, 1'b0, "R10 lone byte");

    // R8: ack holds while idle
    pulse_evt(1'b1);
    send(8'd9, 1, "R8 address");
    repeat (3) @(negedge clk);
    chk("R8 ack holds", ack, 1);
    for (int j = 0; j < 3; j++) send(pk(9, j), 1, "R8 data");
    pulse_evt(1'b0);
    collect(2, 9, 9, "R8 commit");

    // R7: byte during busy is refused and halts the transfer
    pulse_evt(1'b1);
    send(8'd40, 1, "R7 address");
    for (int j = 0; j < 6; j++) send(pk(20, j), 1, "R7 data");
    pulse_evt(1'b1);
    send(8'h33, 0, "R7 byte while busy");
    while (busy) @(negedge clk);
    @(negedge clk);
    send(8'h44, 0, "R7 byte after refusal");
    send(8'h45, 0, "R7 byte after refusal");
    pulse_evt(1'b0);
    chk("R7 no commit busy", busy, 0);
    @(negedge clk);
    chk("R7 no commit write", ram_we, 0);

    // same-cycle overlap: last write of burst and new address byte
    pulse_evt(1'b1);
    send(8'd100, 1, "R11 address A");
    for (int j = 0; j < 5; j++) send(pk(30, j), 1, "R11 data A");
    pulse_evt(1'b1);
    repeat (3) @(negedge clk);
    chk("R4 last write visible", ram_we, 1);
    chk("R4 last write addr", ram_addr, 102);
    chk("R4 last write data", ram_wdata, cval(30, 2));
    chk("R4 busy low on last write", busy, 0);
    send(8'd150, 1, "R11 new address during last write");
    for (int j = 0; j < 3; j++) send(pk(31, j), 1, "R11 data B");
    pulse_evt(1'b0);
    collect(2, 150, 31, "R11 commit B");

    // R9: byte in the same cycle as STOP
    pulse_evt(1'b1);
    send(8'd200, 1, "R9 address");
    send(pk(40, 0), 1, "R9 data");
    send(pk(40, 1), 1, "R9 data");
    byte_vld = 1'b1; byte_data = pk(40, 2); stop_evt = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; stop_evt = 1'b0;
    chk("R9 byte with stop refused", ack, 0);
    collect(1, 200, 40, "R9 commit");
    send(8'h12, 0, "R9 byte after stop");
    chk("R9 no write after stop", ram_we, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule